// File: doc/BRIEF.md
# Multi-master read response router

This block sits on the read side of a small interconnect that links several masters to several slaves. On the request side it widens every read-address ID leaving a master by placing that master's index above the ID bits. Downstream slaves echo the widened ID with each read beat, and the router uses only those upper index bits to send the beat back to the master that asked for it. It strips the index field off before delivery, so a master sees exactly the ID it issued.

Each master has a single read-data port, but several slaves may return data to it at the same time. A per-master arbiter picks one slave round-robin and keeps that choice locked until the last beat of the burst has been accepted. Losing slaves are held off by keeping their ready low, so bursts never interleave on a master's port. Address decoding, the write channels and ordering among same-ID transactions are handled elsewhere.

Top module: `rd_resp_router`

## Requirements
- R1: For every master m, `ar_wide_id_o` slice m equals `{m, ar_id_i slice m}`: the master index fills the upper IDX_W bits, where IDX_W is ceil(log2(N_MST)) with a minimum of 1. The path is combinational.
- R2: A slave beat whose RID upper IDX_W bits equal m is presented only on master m, in the same cycle, when that slave holds the grant. A slave handshake happens in exactly the cycle of the matching master handshake.
- R3: The ID delivered on master m is the low ID_W bits of the granted slave's RID.
- R4: Data, response (2 bits) and last flag reach the master unchanged.
- R5: In any cycle at most one slave completes a handshake toward a given master. Every master handshake pairs with exactly one slave handshake.
- R6: Once a slave's beat is presented to a master, that slave keeps the grant until its last beat has been accepted. Beats from other slaves to that master are not accepted in between.
- R7: When a master's port is free, the grant goes to the first requesting slave in ascending cyclic order, starting one past the slave whose burst ended last on that master. After reset the search starts at slave 0.
- R8: While a master holds ready low, its presented beat stays valid with stable ID, data and last. The granted slave's ready follows that master's ready.
- R9: After reset with no slave valid, all master valids and all slave readies are low.
- R10: Bursts aimed at different masters proceed in the same cycle without waiting for one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ar_id_i | input | N_MST*ID_W | Read-address IDs issued by the masters |
| ar_wide_id_o | output | N_MST*(ID_W+IDX_W) | Widened IDs forwarded toward the slaves |
| s_r_valid_i | input | N_SLV | Read beat valid from each slave |
| s_r_ready_o | output | N_SLV | Ready back to each slave |
| s_r_id_i | input | N_SLV*(ID_W+IDX_W) | Widened RID from each slave |
| s_r_data_i | input | N_SLV*DATA_W | Read data from each slave |
| s_r_resp_i | input | N_SLV*2 | Read response from each slave |
| s_r_last_i | input | N_SLV | Last beat flag from each slave |
| m_r_valid_o | output | N_MST | Read beat valid to each master |
| m_r_ready_i | input | N_MST | Ready from each master |
| m_r_id_o | output | N_MST*ID_W | Stripped RID to each master |
| m_r_data_o | output | N_MST*DATA_W | Read data to each master |
| m_r_resp_o | output | N_MST*2 | Read response to each master |
| m_r_last_o | output | N_MST | Last beat flag to each master |

## Verification
ID widening and beat forwarding are combinational, so the bench drives inputs just after the falling edge and reads the outputs one time step later, still in the same cycle. Grant locking and the round-robin pointer update on the rising edge that accepts a beat, so their effect is checked at the next sample, where the bench advances its own slave models past the accepted beat and expects the next one. Stall stability is compared between consecutive samples of the same master, and burst order is taken from the first beat each master receives after its previous last beat.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int RESP_W = 2;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 3,
  localparam int PW = rrt_pkg::idx_width(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [PW-1:0] ptr_i,
  output logic [N-1:0]  gnt_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = int'(ptr_i) + i;
      if (idx >= N) idx = idx - N;
      if (!found && req_i[idx]) begin
        gnt_o[idx] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/r_port_arb.sv
module r_port_arb #(
  parameter int N_SLV = 3,
  localparam int PW = rrt_pkg::idx_width(N_SLV)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SLV-1:0] req_i,
  input  logic             beat_done_i,
  input  logic             last_i,
  output logic [N_SLV-1:0] gnt_o
);
  logic             locked_q;
  logic [N_SLV-1:0] lock_gnt_q;
  logic [PW-1:0]    ptr_q;
  logic [N_SLV-1:0] pick_gnt;
  logic [PW-1:0]    gnt_idx;
  logic             burst_end;

  rr_pick #(.N(N_SLV)) i_pick (
    .req_i (req_i),
    .ptr_i (ptr_q),
    .gnt_o (pick_gnt)
  );

  assign gnt_o     = locked_q ? lock_gnt_q : pick_gnt;
  assign burst_end = beat_done_i & last_i;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N_SLV; i++)
      if (gnt_o[i]) gnt_idx = PW'(i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q   <= 1'b0;
      lock_gnt_q <= '0;
      ptr_q      <= '0;
    end else if (burst_end) begin
      locked_q <= 1'b0;
      ptr_q    <= (gnt_idx == PW'(N_SLV - 1)) ? '0 : gnt_idx + 1'b1;
    end else if (!locked_q && |pick_gnt) begin
      // hold the choice from the first presented beat on
      locked_q   <= 1'b1;
      lock_gnt_q <= pick_gnt;
    end
  end
endmodule

// File: rtl/r_beat_mux.sv
module r_beat_mux #(
  parameter int N_SLV  = 3,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  localparam int RW    = rrt_pkg::RESP_W
) (
  input  logic [N_SLV-1:0]        sel_i,
  input  logic [N_SLV-1:0]        req_i,
  input  logic [N_SLV*ID_W-1:0]   id_i,
  input  logic [N_SLV*DATA_W-1:0] data_i,
  input  logic [N_SLV*RW-1:0]     resp_i,
  input  logic [N_SLV-1:0]        last_i,
  output logic                    valid_o,
  output logic [ID_W-1:0]         id_o,
  output logic [DATA_W-1:0]       data_o,
  output logic [RW-1:0]           resp_o,
  output logic                    last_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = '0;
    data_o  = '0;
    resp_o  = '0;
    last_o  = 1'b0;
    for (int s = 0; s < N_SLV; s++) begin
      if (sel_i[s]) begin
        valid_o = valid_o | req_i[s];
        id_o    = id_o   | id_i[s*ID_W +: ID_W];
        data_o  = data_o | data_i[s*DATA_W +: DATA_W];
        resp_o  = resp_o | resp_i[s*RW +: RW];
        last_o  = last_o | last_i[s];
      end
    end
  end
endmodule

// File: rtl/rd_resp_router.sv
module rd_resp_router #(
  parameter int N_MST  = 3,
  parameter int N_SLV  = 3,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = rrt_pkg::idx_width(N_MST),
  localparam int SID_W = ID_W + IDX_W,
  localparam int RW    = rrt_pkg::RESP_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_MST*ID_W-1:0]   ar_id_i,
  output logic [N_MST*SID_W-1:0]  ar_wide_id_o,
  input  logic [N_SLV-1:0]        s_r_valid_i,
  output logic [N_SLV-1:0]        s_r_ready_o,
  input  logic [N_SLV*SID_W-1:0]  s_r_id_i,
  input  logic [N_SLV*DATA_W-1:0] s_r_data_i,
  input  logic [N_SLV*RW-1:0]     s_r_resp_i,
  input  logic [N_SLV-1:0]        s_r_last_i,
  output logic [N_MST-1:0]        m_r_valid_o,
  input  logic [N_MST-1:0]        m_r_ready_i,
  output logic [N_MST*ID_W-1:0]   m_r_id_o,
  output logic [N_MST*DATA_W-1:0] m_r_data_o,
  output logic [N_MST*RW-1:0]     m_r_resp_o,
  output logic [N_MST-1:0]        m_r_last_o
);
  logic [N_SLV*ID_W-1:0]         s_id_low;
  logic [N_SLV-1:0][IDX_W-1:0]   s_tgt;
  logic [N_MST-1:0][N_SLV-1:0]   req;
  logic [N_MST-1:0][N_SLV-1:0]   gnt;

  for (genvar m = 0; m < N_MST; m++) begin : g_ar
    assign ar_wide_id_o[m*SID_W +: SID_W] = {IDX_W'(m), ar_id_i[m*ID_W +: ID_W]};
  end

  for (genvar s = 0; s < N_SLV; s++) begin : g_split
    assign s_id_low[s*ID_W +: ID_W] = s_r_id_i[s*SID_W +: ID_W];
    assign s_tgt[s]                 = s_r_id_i[s*SID_W + ID_W +: IDX_W];
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_mst
    for (genvar s = 0; s < N_SLV; s++) begin : g_req
      assign req[m][s] = s_r_valid_i[s] & (s_tgt[s] == IDX_W'(m));
    end

    r_port_arb #(.N_SLV(N_SLV)) i_arb (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .req_i       (req[m]),
      .beat_done_i (m_r_valid_o[m] & m_r_ready_i[m]),
      .last_i      (m_r_last_o[m]),
      .gnt_o       (gnt[m])
    );

    r_beat_mux #(.N_SLV(N_SLV), .ID_W(ID_W), .DATA_W(DATA_W)) i_mux (
      .sel_i   (gnt[m]),
      .req_i   (req[m]),
      .id_i    (s_id_low),
      .data_i  (s_r_data_i),
      .resp_i  (s_r_resp_i),
      .last_i  (s_r_last_i),
      .valid_o (m_r_valid_o[m]),
      .id_o    (m_r_id_o[m*ID_W +: ID_W]),
      .data_o  (m_r_data_o[m*DATA_W +: DATA_W]),
      .resp_o  (m_r_resp_o[m*RW +: RW]),
      .last_o  (m_r_last_o[m])
    );
  end

  // a slave only ever targets one master, so an OR over masters suffices
  always_comb begin
    s_r_ready_o = '0;
    for (int m = 0; m < N_MST; m++)
      s_r_ready_o = s_r_ready_o | (gnt[m] & {N_SLV{m_r_ready_i[m]}});
  end
endmodule

// File: rtl/rd_resp_router_chk.sv
module rd_resp_router_chk #(
  parameter int N_MST  = 3,
  parameter int N_SLV  = 3,
  parameter int ID_W   = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = rrt_pkg::idx_width(N_MST),
  localparam int SID_W = ID_W + IDX_W,
  localparam int RW    = rrt_pkg::RESP_W,
  localparam int SW    = rrt_pkg::idx_width(N_SLV)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_MST*ID_W-1:0]   ar_id_i,
  input logic [N_MST*SID_W-1:0]  ar_wide_id_o,
  input logic [N_SLV-1:0]        s_r_valid_i,
  input logic [N_SLV-1:0]        s_r_ready_o,
  input logic [N_SLV*SID_W-1:0]  s_r_id_i,
  input logic [N_SLV*DATA_W-1:0] s_r_data_i,
  input logic [N_SLV*RW-1:0]     s_r_resp_i,
  input logic [N_SLV-1:0]        s_r_last_i,
  input logic [N_MST-1:0]        m_r_valid_o,
  input logic [N_MST-1:0]        m_r_ready_i,
  input logic [N_MST*ID_W-1:0]   m_r_id_o,
  input logic [N_MST*DATA_W-1:0] m_r_data_o,
  input logic [N_MST*RW-1:0]     m_r_resp_o,
  input logic [N_MST-1:0]        m_r_last_o
);
  logic [N_MST-1:0][N_SLV-1:0] hs_vec;
  logic [N_MST-1:0]            own_v;
  logic [N_MST-1:0][SW-1:0]    own_s;

  always_comb begin
    for (int m = 0; m < N_MST; m++)
      for (int s = 0; s < N_SLV; s++)
        hs_vec[m][s] = s_r_valid_i[s] & s_r_ready_o[s] &
                       (s_r_id_i[s*SID_W + ID_W +: IDX_W] == IDX_W'(m));
  end

  for (genvar m = 0; m < N_MST; m++) begin : g_m
    logic          hs_any, hs_last;
    logic [SW-1:0] hs_idx;

    always_comb begin
      hs_any  = 1'b0;
      hs_last = 1'b0;
      hs_idx  = '0;
      for (int s = 0; s < N_SLV; s++)
        if (hs_vec[m][s]) begin
          hs_any  = 1'b1;
          hs_last = s_r_last_i[s];
          hs_idx  = SW'(s);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        own_v[m] <= 1'b0;
        own_s[m] <= '0;
      end else if (hs_any) begin
        own_v[m] <= !hs_last;
        own_s[m] <= hs_idx;
      end
    end

    // R1
    ar_id_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ar_wide_id_o[m*SID_W +: SID_W] == {IDX_W'(m), ar_id_i[m*ID_W +: ID_W]});

    // R5
    one_winner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(hs_vec[m]) <= 1);

    // R8
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (m_r_valid_o[m] && !m_r_ready_i[m]) |=> (m_r_valid_o[m]
        && $stable(m_r_data_o[m*DATA_W +: DATA_W])
        && $stable(m_r_id_o[m*ID_W +: ID_W]) && $stable(m_r_last_o[m])));

    for (genvar s = 0; s < N_SLV; s++) begin : g_s
      // R2 R3 R4
      beat_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hs_vec[m][s] |-> (m_r_valid_o[m] && m_r_ready_i[m]
          && m_r_id_o[m*ID_W +: ID_W] == s_r_id_i[s*SID_W +: ID_W]
          && m_r_data_o[m*DATA_W +: DATA_W] == s_r_data_i[s*DATA_W +: DATA_W]
          && m_r_resp_o[m*RW +: RW] == s_r_resp_i[s*RW +: RW]
          && m_r_last_o[m] == s_r_last_i[s]));

      // R6
      burst_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (own_v[m] && hs_vec[m][s]) |-> (own_s[m] == SW'(s)));
    end
  end
endmodule

bind rd_resp_router rd_resp_router_chk #(
  .N_MST(N_MST), .N_SLV(N_SLV), .ID_W(ID_W), .DATA_W(DATA_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ar_id_i(ar_id_i), .ar_wide_id_o(ar_wide_id_o),
  .s_r_valid_i(s_r_valid_i), .s_r_ready_o(s_r_ready_o), .s_r_id_i(s_r_id_i),
  .s_r_data_i(s_r_data_i), .s_r_resp_i(s_r_resp_i), .s_r_last_i(s_r_last_i),
  .m_r_valid_o(m_r_valid_o), .m_r_ready_i(m_r_ready_i), .m_r_id_o(m_r_id_o),
  .m_r_data_o(m_r_data_o), .m_r_resp_o(m_r_resp_o), .m_r_last_o(m_r_last_o)
);

// File: tb/test_rd_resp_router.sv
module test_rd_resp_router;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 3, NS = 3, IDW = 4, DW = 32, XW = 2, SW = IDW + XW;
  localparam int MAXB = 64;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic [NM*IDW-1:0] ar_id_i = '0;
  logic [NM*SW-1:0]  ar_wide_id_o;
  logic [NS-1:0]     s_r_valid_i = '0, s_r_ready_o, s_r_last_i = '0;
  logic [NS*SW-1:0]  s_r_id_i = '0;
  logic [NS*DW-1:0]  s_r_data_i = '0;
  logic [NS*2-1:0]   s_r_resp_i = '0;
  logic [NM-1:0]     m_r_valid_o, m_r_ready_i = '0, m_r_last_o;
  logic [NM*IDW-1:0] m_r_id_o;
  logic [NM*DW-1:0]  m_r_data_o;
  logic [NM*2-1:0]   m_r_resp_o;

  rd_resp_router #(.N_MST(NM), .N_SLV(NS), .ID_W(IDW), .DATA_W(DW)) i_rd_resp_router (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_err = 0;
  int nb[NS], pos[NS], bt[NS];
  int b_tgt[NS][MAXB], b_id[NS][MAXB], b_len[NS][MAXB];
  logic drv_v[NS], hs_prev[NS];
  int cur_act[NM], cur_s[NM];
  logic st_v[NM];
  logic [DW-1:0] st_d[NM];
  logic [IDW-1:0] st_id[NM];
  int start_log[16], n_start;
  int vpct = 100, rpct = 100;
  bit saw_par;

  task automatic chk(input bit ok, input string tag, input string msg,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, msg, act, exp);
    end
  endtask

  task automatic clear_bursts();
    for (int s = 0; s < NS; s++) begin
      nb[s] = 0; pos[s] = 0; bt[s] = 0; drv_v[s] = 1'b0; hs_prev[s] = 1'b0;
    end
    for (int m = 0; m < NM; m++) begin cur_act[m] = 0; st_v[m] = 1'b0; end
    n_start = 0;
    saw_par = 1'b0;
  endtask

  task automatic add_burst(input int s, input int tgt, input int id, input int len);
    b_tgt[s][nb[s]] = tgt; b_id[s][nb[s]] = id; b_len[s][nb[s]] = len;
    nb[s]++;
  endtask

  task automatic drive_slave(input int s);
    int k;
    k = (pos[s] < nb[s]) ? pos[s] : 0;
    s_r_valid_i[s] = drv_v[s];
    s_r_data_i[s*DW +: DW] = {8'(s), 8'(k), 8'(bt[s]), 8'(b_tgt[s][k])};
    s_r_id_i[s*SW +: SW]   = {XW'(b_tgt[s][k]), IDW'(b_id[s][k])};
    s_r_resp_i[s*2 +: 2]   = 2'((k + bt[s]) & 3);
    s_r_last_i[s]          = (bt[s] == b_len[s][k] - 1);
  endtask

  task automatic sample_check();
    int n_mhs;
    n_mhs = 0;
    for (int s = 0; s < NS; s++) hs_prev[s] = s_r_valid_i[s] & s_r_ready_o[s];
    for (int m = 0; m < NM; m++) begin
      int nhs;
      logic mhs;
      logic [DW-1:0] d;
      nhs = 0;
      for (int s = 0; s < NS; s++)
        if (hs_prev[s] && b_tgt[s][pos[s]] == m) nhs++;
      mhs = m_r_valid_o[m] & m_r_ready_i[m];
      d = m_r_data_o[m*DW +: DW];
      if (mhs) n_mhs++;
      if (nhs > 0 || mhs)
        chk(nhs == int'(mhs), "R5", "slave handshakes per master beat", nhs, int'(mhs));
      if (st_v[m])
        chk(m_r_valid_o[m] && d == st_d[m] && m_r_id_o[m*IDW +: IDW] == st_id[m],
            "R8", "stalled beat not held", d, st_d[m]);
      st_v[m] = m_r_valid_o[m] & !m_r_ready_i[m];
      st_d[m] = d;
      st_id[m] = m_r_id_o[m*IDW +: IDW];
      if (mhs) begin
        int s, k, b;
        s = int'(d[31:24]); k = int'(d[23:16]); b = int'(d[15:8]);
        if (s >= NS) begin
          chk(1'b0, "R2", "beat from unknown slave", s, 0);
        end else begin
          chk(hs_prev[s] && pos[s] == k && bt[s] == b && int'(d[7:0]) == m,
              "R2", "beat routing", d, {8'(s), 8'(pos[s]), 8'(bt[s]), 8'(m)});
          chk(m_r_id_o[m*IDW +: IDW] == IDW'(b_id[s][k]), "R3", "stripped id",
              m_r_id_o[m*IDW +: IDW], b_id[s][k]);
          chk(m_r_last_o[m] == (b == b_len[s][k] - 1) &&
              m_r_resp_o[m*2 +: 2] == 2'((k + b) & 3), "R4", "last/resp passthrough",
              {m_r_last_o[m], m_r_resp_o[m*2 +: 2]}, {(b == b_len[s][k] - 1), 2'((k + b) & 3)});
          if (cur_act[m] != 0)
            chk(s == cur_s[m], "R6", "burst interleaved", s, cur_s[m]);
          else if (m == 0 && n_start < 16) begin
            start_log[n_start] = s;
            n_start++;
          end
          cur_act[m] = m_r_last_o[m] ? 0 : 1;
          cur_s[m] = s;
        end
      end
    end
    if (n_mhs > 1) saw_par = 1'b1;
  endtask

  task automatic run_cycle();
    @(negedge clk_i);
    for (int s = 0; s < NS; s++)
      if (hs_prev[s]) begin
        bt[s]++;
        if (bt[s] == b_len[s][pos[s]]) begin bt[s] = 0; pos[s]++; end
      end
    for (int s = 0; s < NS; s++) begin
      if (!(drv_v[s] && !hs_prev[s]))
        drv_v[s] = (pos[s] < nb[s]) && ($urandom_range(99) < vpct);
      drive_slave(s);
    end
    for (int m = 0; m < NM; m++) m_r_ready_i[m] = ($urandom_range(99) < rpct);
    #1;
    sample_check();
  endtask

  task automatic run_until_done(input int limit);
    int cyc;
    bit done;
    cyc = 0;
    done = 1'b0;
    while (!done && cyc < limit) begin
      run_cycle();
      cyc++;
      done = 1'b1;
      for (int s = 0; s < NS; s++) if (pos[s] < nb[s]) done = 1'b0;
    end
    chk(done, "R2", "all bursts delivered", cyc, limit);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_err++;
    $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", 150000, 0);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    clear_bursts();
    m_r_ready_i = '1;
    repeat (3) @(negedge clk_i);
    #1;
    // R9 reset state
    chk(m_r_valid_o == '0 && s_r_ready_o == '0, "R9", "outputs during reset",
        {m_r_valid_o, s_r_ready_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    run_cycle();
    chk(m_r_valid_o == '0 && s_r_ready_o == '0, "R9", "idle after reset",
        {m_r_valid_o, s_r_ready_o}, 0);

    // R1 id widening
    for (int t = 0; t < 20; t++) begin
      ar_id_i = NM*IDW'($urandom);
      #1;
      for (int m = 0; m < NM; m++)
        chk(ar_wide_id_o[m*SW +: SW] == {XW'(m), ar_id_i[m*IDW +: IDW]}, "R1",
            "widened id", ar_wide_id_o[m*SW +: SW], {XW'(m), ar_id_i[m*IDW +: IDW]});
    end

    // R7 round-robin on master 0: slave 0 alone moves the pointer to 1
    vpct = 100; rpct = 100;
    clear_bursts();
    add_burst(0, 0, 3, 2);
    run_until_done(50);
    clear_bursts();
    add_burst(0, 0, 5, 2);
    add_burst(2, 0, 9, 3);
    run_until_done(50);
    chk(n_start == 2 && start_log[0] == 2 && start_log[1] == 0, "R7",
        "order with pointer at 1", {start_log[0], start_log[1]}, {32'd2, 32'd0});
    // pointer now at 1 again: all three contend
    clear_bursts();
    for (int s = 0; s < NS; s++) add_burst(s, 0, s + 1, 2);
    run_until_done(50);
    chk(n_start == 3 && start_log[0] == 1 && start_log[1] == 2 && start_log[2] == 0,
        "R7", "order with all contending", start_log[0], 1);

    // R6 lock under master stalls
    rpct = 40;
    clear_bursts();
    add_burst(0, 1, 7, 4); add_burst(1, 1, 8, 4); add_burst(2, 1, 2, 1);
    run_until_done(200);

    // R10 independent masters
    rpct = 100;
    clear_bursts();
    add_burst(0, 0, 1, 3); add_burst(1, 1, 2, 3); add_burst(2, 2, 4, 3);
    run_until_done(50);
    chk(saw_par, "R10", "parallel delivery to distinct masters", saw_par, 1);

    // random traffic
    vpct = 70; rpct = 60;
    clear_bursts();
    for (int s = 0; s < NS; s++)
      for (int k = 0; k < 40; k++)
        add_burst(s, $urandom_range(NM - 1), $urandom_range(15), $urandom_range(1, 6));
    run_until_done(6000);

    finish_run();
  end
endmodule